// File: doc/BRIEF.md
# Watchdog Timer with Timed Configuration Unlock

This block is a watchdog timer for a system-on-chip. A counter runs on its own watchdog clock and, unless software clears it in time through a kick input, it raises a reset request for one watchdog-clock cycle when it reaches the selected timeout. Software controls the timer through a small control register, written and read over a synchronous port on the system clock. The register holds a change-enable bit, an enable bit and a prescaler field.

To stop runaway code from turning the timer off or stretching its period, changes go through a two-step unlock. First, one write sets both the change-enable bit and the enable bit. Then a second write, with change-enable clear, must land within four system-clock cycles to apply the new setting. Any other attempt is refused.

A static strap input selects the safety level. At level one the timer starts disabled and any plain write can switch it on. At level two it is always running and can never be switched off. Configuration crosses from the system clock to the watchdog clock through a request/acknowledge handshake, and so do kicks.

Top module: `wdg_timed_lock`

## Requirements
- R1: After system reset at level one (`lvl2_i`=0), a read returns 0: change-enable 0, enable 0, prescaler 0. The register layout for both writes and reads is bit 4 change-enable, bit 3 enable, bits 2:0 prescaler.
- R2: At level one, a plain write (bit 4 = 0, no open window) with bit 3 = 1 enables the timer at once. The prescaler bits of that write are ignored.
- R3: A plain write with bit 3 = 0 never disables an enabled timer, and a plain write never changes the prescaler.
- R4: A write with bits 4 and 3 both set opens the change window, and change-enable reads as 1 while it is open. The window closes by itself after four system-clock cycles, after which change-enable reads 0.
- R5: A second write with bit 4 = 0, landing 1 to 4 system-clock cycles after the opening write, applies its prescaler and (at level one) its enable bit.
- R6: A second write landing 5 or more cycles after the opening write is refused, and the prescaler keeps its old value.
- R7: At level one, the timed sequence with enable 0 in the second write disables the timer.
- R8: A write with bit 4 = 1 but bit 3 = 0 does not open the window, so a following write is refused.
- R9: At level two (`lvl2_i`=1), enable always reads 1 and cannot be cleared by any write. The timed sequence still changes the prescaler, and the timer keeps timing out with the new period.
- R10: While enabled and not kicked, `wdt_reset_o` pulses once every 2^(TIMEOUT_BASE_LOG2 + n) watchdog-clock cycles, where n is the prescaler value.
- R11: A `kick_i` pulse restarts the count from zero. Kicks spaced well inside the timeout prevent any reset request.
- R12: While disabled, the timer produces no reset request.
- R13: Each reset request is exactly one watchdog-clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the register port and kicks |
| sys_rst_n | input | 1 | Asynchronous active-low reset, system domain |
| wdt_clk | input | 1 | Dedicated watchdog clock |
| wdt_rst_n | input | 1 | Asynchronous active-low reset, watchdog domain |
| lvl2_i | input | 1 | Safety-level strap, 1 selects level two (static) |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | PSEL_W+2 | Write data: change-enable, enable, prescaler |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | PSEL_W+2 | Read data, valid the cycle after `rd_en_i` |
| kick_i | input | 1 | One-cycle pulse that restarts the count |
| wdt_reset_o | output | 1 | One-cycle reset request on timeout, watchdog domain |

## Verification
The window edge gets the closest look. A second write four cycles after the opening write must be accepted, and one five cycles after must be refused. A design with an off-by-one window counter would fail one of these two cases. The bench also tries to open the window with the enable bit clear, which a design that decodes only change-enable would wrongly accept. It tries to disable through plain writes and at level two, where a design that let the enable bit through would stop the reset pulses. Finally, it measures the exact spacing between reset pulses for two prescaler values, at both levels, so that a wrong shift base or a counter that skips its terminal value shows up as a wrong interval.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   typedef enum logic {
      WDG_LEVEL_ONE = 1'b0,
      WDG_LEVEL_TWO = 1'b1
   } wdg_level_e;

   localparam int unsigned WDG_DEF_WINDOW = 4;
   localparam int unsigned WDG_DEF_STAGES = 2;

   // Width of the counter needed to reach the longest timeout.
   function automatic int unsigned wdg_cnt_width(input int unsigned base_log2,
                                                 input int unsigned psel_w);
      return base_log2 + (1 << psel_w) - 1;
   endfunction

   // Width of the window down-counter.
   function automatic int unsigned wdg_win_width(input int unsigned window);
      return $clog2(window + 1);
   endfunction

endpackage

// File: rtl/wdg_sync_bit.sv
module wdg_sync_bit #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] ff_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q[0] <= 1'b0;
            else        ff_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q[i] <= 1'b0;
            else        ff_q[i] <= ff_q[i-1];
         end
      end
   end

   assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/wdg_hs_xfer.sv
module wdg_hs_xfer #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         src_clk,
   input  logic         src_rst_n,
   input  logic         src_load,
   input  logic [W-1:0] src_data,
   input  logic         dst_clk,
   input  logic         dst_rst_n,
   output logic         dst_valid,
   output logic [W-1:0] dst_data
);

   logic         req_q;
   logic         ack_s;
   logic         req_s;
   logic         req_d;
   logic         pend_q;
   logic [W-1:0] pend_data_q;
   logic [W-1:0] hold_q;
   logic         launch;

   // A new request starts only when the previous four-phase cycle is over.
   assign launch = !req_q && !ack_s && (pend_q || src_load);

   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n) begin
         req_q       <= 1'b0;
         pend_q      <= 1'b0;
         pend_data_q <= '0;
         hold_q      <= '0;
      end else begin
         if (src_load) begin
            pend_q      <= 1'b1;
            pend_data_q <= src_data;
         end
         if (launch) begin
            req_q  <= 1'b1;
            hold_q <= src_load ? src_data : pend_data_q;
            pend_q <= 1'b0;
         end else if (req_q && ack_s) begin
            req_q <= 1'b0;
         end
      end
   end

   wdg_sync_bit #(.STAGES(STAGES)) u_req_sync (
      .clk   (dst_clk),
      .rst_n (dst_rst_n),
      .d_i   (req_q),
      .q_o   (req_s)
   );

   wdg_sync_bit #(.STAGES(STAGES)) u_ack_sync (
      .clk   (src_clk),
      .rst_n (src_rst_n),
      .d_i   (req_s),
      .q_o   (ack_s)
   );

   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) begin
         req_d     <= 1'b0;
         dst_valid <= 1'b0;
         dst_data  <= '0;
      end else begin
         req_d     <= req_s;
         dst_valid <= req_s && !req_d;
         if (req_s && !req_d) dst_data <= hold_q;
      end
   end

endmodule

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs #(
   parameter int unsigned PSEL_W = 3,
   parameter int unsigned WINDOW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lvl2_i,
   input  logic              wr_en_i,
   input  logic [PSEL_W+1:0] wr_data_i,
   input  logic              rd_en_i,
   output logic [PSEL_W+1:0] rd_data_o,
   output logic              en_q,
   output logic [PSEL_W-1:0] psel_q,
   output logic              win_open_o,
   output logic              cfg_load_o
);

   import wdg_pkg::*;

   localparam int unsigned WIN_W  = wdg_win_width(WINDOW);
   localparam int unsigned BIT_EN = PSEL_W;
   localparam int unsigned BIT_CE = PSEL_W + 1;

   logic [WIN_W-1:0]  win_cnt_q;
   logic              wr_ce;
   logic              wr_en_bit;
   logic [PSEL_W-1:0] wr_psel;
   logic              arm;
   logic              commit;
   logic              en_nxt;
   logic [PSEL_W-1:0] psel_nxt;
   wdg_level_e        level;

   assign level      = wdg_level_e'(lvl2_i);
   assign wr_ce      = wr_data_i[BIT_CE];
   assign wr_en_bit  = wr_data_i[BIT_EN];
   assign wr_psel    = wr_data_i[PSEL_W-1:0];
   assign win_open_o = (win_cnt_q != '0);
   assign arm        = wr_en_i && wr_ce && wr_en_bit;
   assign commit     = wr_en_i && !wr_ce && win_open_o;

   always_comb begin
      en_nxt   = en_q;
      psel_nxt = psel_q;
      if (commit) psel_nxt = wr_psel;
      if (level == WDG_LEVEL_ONE) begin
         if (commit)                    en_nxt = wr_en_bit;
         else if (wr_en_i && wr_en_bit) en_nxt = 1'b1;
      end
   end

   assign cfg_load_o = (en_nxt != en_q) || (psel_nxt != psel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt_q <= '0;
         en_q      <= 1'b0;
         psel_q    <= '0;
         rd_data_o <= '0;
      end else begin
         if (arm)             win_cnt_q <= WIN_W'(WINDOW);
         else if (commit)     win_cnt_q <= '0;
         else if (win_open_o) win_cnt_q <= win_cnt_q - 1'b1;
         en_q   <= en_nxt;
         psel_q <= psel_nxt;
         if (rd_en_i) rd_data_o <= {win_open_o, en_q || (level == WDG_LEVEL_TWO), psel_q};
      end
   end

endmodule

// File: rtl/wdg_wdt_counter.sv
module wdg_wdt_counter #(
   parameter int unsigned PSEL_W            = 3,
   parameter int unsigned TIMEOUT_BASE_LOG2 = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lvl2_i,
   input  logic            cfg_vld_i,
   input  logic [PSEL_W:0] cfg_data_i,
   input  logic            kick_i,
   output logic            en_o,
   output logic            rst_req_o
);

   import wdg_pkg::*;

   localparam int unsigned CNT_W = wdg_cnt_width(TIMEOUT_BASE_LOG2, PSEL_W);

   logic              en_q;
   logic [PSEL_W-1:0] psel_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W:0]    span;
   logic [CNT_W-1:0]  limit;

   assign en_o  = en_q || lvl2_i;
   assign span  = (CNT_W+1)'(1) << (TIMEOUT_BASE_LOG2 + int'(psel_q));
   assign limit = CNT_W'(span - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         psel_q    <= '0;
         cnt_q     <= '0;
         rst_req_o <= 1'b0;
      end else begin
         if (cfg_vld_i) {en_q, psel_q} <= cfg_data_i;
         if (!en_o || kick_i) begin
            cnt_q     <= '0;
            rst_req_o <= 1'b0;
         end else if (cnt_q >= limit) begin
            cnt_q     <= '0;
            rst_req_o <= 1'b1;
         end else begin
            cnt_q     <= cnt_q + 1'b1;
            rst_req_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/wdg_timed_lock.sv
module wdg_timed_lock #(
   parameter int unsigned PSEL_W            = 3,
   parameter int unsigned TIMEOUT_BASE_LOG2 = 10,
   parameter int unsigned WINDOW            = wdg_pkg::WDG_DEF_WINDOW,
   parameter int unsigned SYNC_STAGES       = wdg_pkg::WDG_DEF_STAGES
) (
   input  logic              sys_clk,
   input  logic              sys_rst_n,
   input  logic              wdt_clk,
   input  logic              wdt_rst_n,
   input  logic              lvl2_i,
   input  logic              wr_en_i,
   input  logic [PSEL_W+1:0] wr_data_i,
   input  logic              rd_en_i,
   output logic [PSEL_W+1:0] rd_data_o,
   input  logic              kick_i,
   output logic              wdt_reset_o
);

   if (PSEL_W < 1 || PSEL_W > 4) begin : g_bad_psel
      $error("wdg_timed_lock: PSEL_W must lie in 1..4");
   end
   if (TIMEOUT_BASE_LOG2 < 2) begin : g_bad_base
      $error("wdg_timed_lock: TIMEOUT_BASE_LOG2 must be at least 2");
   end
   if (WINDOW < 1) begin : g_bad_window
      $error("wdg_timed_lock: WINDOW must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wdg_timed_lock: SYNC_STAGES must be at least 2");
   end

   logic              en_q;
   logic [PSEL_W-1:0] psel_q;
   logic              win_open;
   logic              cfg_load;
   logic              cfg_vld;
   logic [PSEL_W:0]   cfg_data;
   logic              kick_vld;
   logic              kick_tag;
   logic              kick_hit;
   logic              wdt_en;

   wdg_cfg_regs #(
      .PSEL_W (PSEL_W),
      .WINDOW (WINDOW)
   ) u_regs (
      .clk        (sys_clk),
      .rst_n      (sys_rst_n),
      .lvl2_i     (lvl2_i),
      .wr_en_i    (wr_en_i),
      .wr_data_i  (wr_data_i),
      .rd_en_i    (rd_en_i),
      .rd_data_o  (rd_data_o),
      .en_q       (en_q),
      .psel_q     (psel_q),
      .win_open_o (win_open),
      .cfg_load_o (cfg_load)
   );

   wdg_hs_xfer #(
      .W      (PSEL_W + 1),
      .STAGES (SYNC_STAGES)
   ) u_cfg_xfer (
      .src_clk   (sys_clk),
      .src_rst_n (sys_rst_n),
      .src_load  (cfg_load),
      .src_data  ({u_regs.en_nxt, u_regs.psel_nxt}),
      .dst_clk   (wdt_clk),
      .dst_rst_n (wdt_rst_n),
      .dst_valid (cfg_vld),
      .dst_data  (cfg_data)
   );

   wdg_hs_xfer #(
      .W      (1),
      .STAGES (SYNC_STAGES)
   ) u_kick_xfer (
      .src_clk   (sys_clk),
      .src_rst_n (sys_rst_n),
      .src_load  (kick_i),
      .src_data  (1'b1),
      .dst_clk   (wdt_clk),
      .dst_rst_n (wdt_rst_n),
      .dst_valid (kick_vld),
      .dst_data  (kick_tag)
   );

   assign kick_hit = kick_vld && kick_tag;

   wdg_wdt_counter #(
      .PSEL_W            (PSEL_W),
      .TIMEOUT_BASE_LOG2 (TIMEOUT_BASE_LOG2)
   ) u_cnt (
      .clk        (wdt_clk),
      .rst_n      (wdt_rst_n),
      .lvl2_i     (lvl2_i),
      .cfg_vld_i  (cfg_vld),
      .cfg_data_i (cfg_data),
      .kick_i     (kick_hit),
      .en_o       (wdt_en),
      .rst_req_o  (wdt_reset_o)
   );

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
   parameter int unsigned PSEL_W = 3,
   parameter int unsigned WINDOW = 4
) (
   input logic              sys_clk,
   input logic              sys_rst_n,
   input logic              wdt_clk,
   input logic              wdt_rst_n,
   input logic              wr_en_i,
   input logic [PSEL_W+1:0] wr_data_i,
   input logic              win_open,
   input logic              en_q,
   input logic [PSEL_W-1:0] psel_q,
   input logic              wdt_en,
   input logic              wdt_reset_o
);

   logic [7:0] age_q;
   logic       arm_seen;

   assign arm_seen = wr_en_i && wr_data_i[PSEL_W+1] && wr_data_i[PSEL_W];

   // Cycles since the last opening write, saturating.
   always_ff @(posedge sys_clk or negedge sys_rst_n) begin
      if (!sys_rst_n)          age_q <= 8'hFF;
      else if (arm_seen)       age_q <= 8'd0;
      else if (age_q != 8'hFF) age_q <= age_q + 8'd1;
   end

   p_window_bound_r4: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      win_open |-> (age_q < 8'(WINDOW)));

   p_no_plain_disable_r3: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (en_q && !win_open) |=> en_q);

   p_psel_locked_r6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      !(wr_en_i && win_open) |=> $stable(psel_q));

   p_quiet_when_off_r12: assert property (@(posedge wdt_clk) disable iff (!wdt_rst_n)
      !wdt_en |=> !wdt_reset_o);

   p_single_pulse_r13: assert property (@(posedge wdt_clk) disable iff (!wdt_rst_n)
      wdt_reset_o |=> !wdt_reset_o);

endmodule

bind wdg_timed_lock wdg_checker #(
   .PSEL_W (PSEL_W),
   .WINDOW (WINDOW)
) u_chk (
   .sys_clk     (sys_clk),
   .sys_rst_n   (sys_rst_n),
   .wdt_clk     (wdt_clk),
   .wdt_rst_n   (wdt_rst_n),
   .wr_en_i     (wr_en_i),
   .wr_data_i   (wr_data_i),
   .win_open    (win_open),
   .en_q        (en_q),
   .psel_q      (psel_q),
   .wdt_en      (wdt_en),
   .wdt_reset_o (wdt_reset_o)
);

// File: tb/test_wdg_timed_lock.sv
`timescale 1ns/1ps
module test_wdg_timed_lock;

   localparam int unsigned PW   = 3;
   localparam int unsigned BASE = 4;
   localparam int unsigned DW   = PW + 2;

   logic          sys_clk = 1'b0;
   logic          wdt_clk = 1'b0;
   logic          sys_rst_n = 1'b0;
   logic          wdt_rst_n = 1'b0;
   logic          lvl2 = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] rd_data;
   logic          kick = 1'b0;
   logic          wdt_reset;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } rd_item_t;
   rd_item_t sb_q[$];

   int   wcyc = 0;
   int   last_pulse = 0;
   int   last_iv = 0;
   int   pulse_cnt = 0;
   int   wide_cnt = 0;
   logic prev_pulse = 1'b0;

   always #2 sys_clk = ~sys_clk;   // 250 MHz
   always #5 wdt_clk = ~wdt_clk;

   wdg_timed_lock #(
      .PSEL_W            (PW),
      .TIMEOUT_BASE_LOG2 (BASE)
   ) i_wdg_timed_lock (
      .sys_clk     (sys_clk),
      .sys_rst_n   (sys_rst_n),
      .wdt_clk     (wdt_clk),
      .wdt_rst_n   (wdt_rst_n),
      .lvl2_i      (lvl2),
      .wr_en_i     (wr_en),
      .wr_data_i   (wr_data),
      .rd_en_i     (rd_en),
      .rd_data_o   (rd_data),
      .kick_i      (kick),
      .wdt_reset_o (wdt_reset)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Read scoreboard monitor.
   initial begin
      forever begin
         @(posedge sys_clk);
         if (rd_en === 1'b1) begin
            @(negedge sys_clk);
            if (sb_q.size() == 0) begin
               chk(1'b0, "unexpected read", int'(rd_data), 0);
            end else begin
               rd_item_t it;
               it = sb_q.pop_front();
               chk(rd_data === it.exp, it.tag, int'(rd_data), int'(it.exp));
            end
         end
      end
   end

   // Reset-request monitor.
   always @(negedge wdt_clk) begin
      if (!wdt_rst_n) begin
         wcyc = 0; last_pulse = 0; last_iv = 0; pulse_cnt = 0; prev_pulse = 1'b0;
      end else begin
         wcyc++;
         if (wdt_reset === 1'b1) begin
            if (prev_pulse) wide_cnt++;
            if (pulse_cnt > 0) last_iv = wcyc - last_pulse;
            last_pulse = wcyc;
            pulse_cnt++;
         end
         prev_pulse = (wdt_reset === 1'b1);
      end
   end

   task automatic wr(input logic [DW-1:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge sys_clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [DW-1:0] exp, input string tag);
      rd_item_t it;
      it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      rd_en = 1'b1;
      @(negedge sys_clk);
      rd_en = 1'b0;
      @(negedge sys_clk);
   endtask

   // Opening write, gap idle cycles, then the setting write.
   task automatic seq(input int gap, input logic [DW-1:0] d);
      wr(5'b11_000);
      repeat (gap) @(negedge sys_clk);
      wr(d);
   endtask

   task automatic do_reset(input logic level);
      @(negedge sys_clk);
      sys_rst_n = 1'b0; wdt_rst_n = 1'b0; lvl2 = level;
      repeat (10) @(negedge sys_clk);
      sys_rst_n = 1'b1;
      @(negedge wdt_clk); wdt_rst_n = 1'b1;
      repeat (4) @(negedge sys_clk);
   endtask

   task automatic wait_pulses(input int n);
      int target;
      target = pulse_cnt + n;
      while (pulse_cnt < target) @(negedge wdt_clk);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int snap;
      // ---------------- level one ----------------
      do_reset(1'b0);
      rd(5'b00_000, "R1 reset value");
      wr(5'b01_011);
      rd(5'b01_000, "R2 plain enable, prescaler ignored");
      wr(5'b00_101);
      rd(5'b01_000, "R3 plain write cannot disable or retune");
      seq(4, 5'b00_010);
      rd(5'b01_000, "R6 late write at cycle 5 refused");
      seq(3, 5'b01_010);
      rd(5'b01_010, "R5 write at cycle 4 accepted");
      wr(5'b11_000);
      rd(5'b11_010, "R4 change-enable reads 1 in window");
      repeat (6) @(negedge sys_clk);
      rd(5'b01_010, "R4 change-enable self-clears");
      wr(5'b10_000);
      wr(5'b00_101);
      rd(5'b01_010, "R8 unlock without enable bit refused");
      seq(0, 5'b00_000);
      rd(5'b00_000, "R7 timed disable");

      // Timeout period.
      seq(0, 5'b01_000);
      wait_pulses(3);
      chk(last_iv == (1 << BASE), "R10 period prescaler 0", last_iv, 1 << BASE);
      seq(1, 5'b01_010);
      wait_pulses(3);
      chk(last_iv == (1 << (BASE + 2)), "R10 period prescaler 2", last_iv, 1 << (BASE + 2));

      // Kicks hold off the reset request.
      wait_pulses(1);
      @(negedge sys_clk);
      snap = pulse_cnt;
      for (int k = 0; k < 20; k++) begin
         kick = 1'b1;
         @(negedge sys_clk);
         kick = 1'b0;
         repeat (49) @(negedge sys_clk);
      end
      chk(pulse_cnt == snap, "R11 kicks prevent timeout", pulse_cnt - snap, 0);

      // Disabled: no reset request.
      seq(2, 5'b00_010);
      repeat (60) @(negedge sys_clk);
      snap = pulse_cnt;
      repeat (300) @(negedge wdt_clk);
      chk(pulse_cnt == snap, "R12 no pulse while disabled", pulse_cnt - snap, 0);

      // ---------------- level two ----------------
      do_reset(1'b1);
      rd(5'b01_000, "R9 level two reads enabled from reset");
      wr(5'b00_000);
      rd(5'b01_000, "R9 plain disable ignored at level two");
      seq(2, 5'b00_001);
      rd(5'b01_001, "R9 timed write retunes, enable stays 1");
      wait_pulses(3);
      chk(last_iv == (1 << (BASE + 1)), "R9 level two keeps timing out", last_iv, 1 << (BASE + 1));

      chk(wide_cnt == 0, "R13 pulse width one cycle", wide_cnt, 0);
      repeat (4) @(negedge sys_clk);
      chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule